// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides whether an incoming CAN frame is kept or dropped. It holds four programmable filters. Each filter has a mask word and a reference identifier word, and each has its own enable bit. When the receive path presents a 32-bit identifier word together with a one-cycle frame-valid strobe, every enabled filter compares the identifier against its reference under its mask. One clock later the block reports a verdict: keep or drop, whether a filter actually hit, and which filter hit.

Software programs the bank through a simple register bus. The expected sequence is to clear the enable bits, load the mask and reference pairs, and then set the enables again. A filter's mask and reference cannot be changed while that filter is enabled. When no filter is enabled, the bank lets every frame through. The receive logic downstream uses the keep/drop verdict to decide whether to store the frame and raise its receive-done flag.

Top module: `rxflt_bank`

## Requirements
- R1: After reset, the enable bits, all masks, all reference words and the read data are zero, and `acc_vld`, `acc_ok`, `acc_hit` and `acc_idx` are all zero.
- R2: Register map, with byte addresses on `bus_addr`:
  - The enable word is at 0x60. Its bits [3:0] enable filters 0 to 3, and its upper bits read back as zero.
  - The mask of filter k is at 0x64+8k and its reference word is at 0x68+8k.
  - A write takes effect on the clock edge that samples `bus_wr`.
- R3: Filter k matches when `(frm_id & mask_k) == (ref_k & mask_k)`. Identifier bits whose mask bit is 0 never affect the result.
- R4: While at least one filter is enabled, a frame is kept (`acc_ok`=1) exactly when at least one enabled filter matches. A disabled filter never causes a hit.
- R5: While the enable word is zero, every frame is kept with `acc_ok`=1 and `acc_hit`=0.
- R6: A write to the mask or the reference word of a filter whose enable bit is set leaves that register unchanged.
- R7: When several enabled filters match, `acc_idx` gives the lowest-numbered one.
- R8: `acc_vld` is high exactly in the cycle after a cycle with `frm_vld` high. While `acc_vld` is low, `acc_ok`, `acc_hit` and `acc_idx` are all zero.
- R9: Addresses outside the map read as zero, and writes to them change no register.
- R10: `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd` high, and holds that value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frm_vld | input | 1 | Received identifier is valid this cycle |
| frm_id | input | 32 | Received identifier word |
| acc_vld | output | 1 | Verdict is valid this cycle |
| acc_ok | output | 1 | Frame is kept |
| acc_hit | output | 1 | An enabled filter matched |
| acc_idx | output | 2 | Lowest matching filter index |

## Verification
The following are checked on every cycle:
- the one-cycle verdict latency, and quiet outputs between verdicts;
- that a hit always implies a keep;
- that an empty enable word keeps the frame with no hit;
- that the reported index is the lowest bit of the enabled-hit vector;
- that a blocked configuration write leaves every mask and reference word unchanged.

Only the bench scenarios can show the rest: that the comparison follows the masked-equality rule for concrete identifiers, that the register map decodes and reads back correctly, that unmapped addresses are inert, and that reprogramming succeeds once the enable bit is cleared. The bench shows these by checking the results against a behavioural model.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;
  localparam int ID_W = 32;

  // masked equality: every bit the mask keeps must agree
  function automatic logic id_match(input logic [ID_W-1:0] fid,
                                    input logic [ID_W-1:0] msk,
                                    input logic [ID_W-1:0] ref_id);
    return ((fid ^ ref_id) & msk) == '0;
  endfunction
endpackage

// File: rtl/rxflt_regs.sv
module rxflt_regs
  import rxflt_pkg::*;
#(
  parameter int NFLT        = 4,
  parameter int AW          = 8,
  parameter int EN_ADDR     = 'h60,
  parameter int PAIR_BASE   = 'h64,
  parameter int PAIR_STRIDE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [ID_W-1:0]           wdata,
  output logic [ID_W-1:0]           rdata,
  output logic [NFLT-1:0]           en_q,
  output logic [NFLT-1:0][ID_W-1:0] mask_q,
  output logic [NFLT-1:0][ID_W-1:0] ref_q,
  output logic                      wr_block
);
  localparam int REF_OFS = 4;

  logic [NFLT-1:0] sel_m, sel_r;
  logic            sel_en;
  logic [ID_W-1:0] rmux;

  assign sel_en = (addr == AW'(EN_ADDR));

  for (genvar k = 0; k < NFLT; k++) begin : g_flt
    logic [ID_W-1:0] m_r, r_r;
    assign sel_m[k] = (addr == AW'(PAIR_BASE + k * PAIR_STRIDE));
    assign sel_r[k] = (addr == AW'(PAIR_BASE + REF_OFS + k * PAIR_STRIDE));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= '0;
        r_r <= '0;
      end else if (wr_en && !en_q[k]) begin
        if (sel_m[k]) m_r <= wdata;
        if (sel_r[k]) r_r <= wdata;
      end
    end

    assign mask_q[k] = m_r;
    assign ref_q[k]  = r_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               en_q <= '0;
    else if (wr_en && sel_en) en_q <= wdata[NFLT-1:0];
  end

  // a configuration write aimed at an enabled filter
  assign wr_block = wr_en && (|((sel_m | sel_r) & en_q));

  always_comb begin
    rmux = '0;
    if (sel_en) rmux = ID_W'(en_q);
    for (int k = 0; k < NFLT; k++) begin
      if (sel_m[k]) rmux = mask_q[k];
      if (sel_r[k]) rmux = ref_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end
endmodule

// File: rtl/rxflt_cmp.sv
module rxflt_cmp
  import rxflt_pkg::*;
(
  input  logic            on,
  input  logic [ID_W-1:0] fid,
  input  logic [ID_W-1:0] msk,
  input  logic [ID_W-1:0] ref_id,
  output logic            hit
);
  assign hit = on && id_match(fid, msk, ref_id);
endmodule

// File: rtl/rxflt_pick.sv
module rxflt_pick #(
  parameter int NFLT = 4,
  parameter int IW   = $clog2(NFLT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_vld,
  input  logic [NFLT-1:0] hit_vec,
  input  logic [NFLT-1:0] en_q,
  output logic            acc_vld,
  output logic            acc_ok,
  output logic            acc_hit,
  output logic [IW-1:0]   acc_idx
);
  logic [IW-1:0] win_idx;
  logic          found;

  always_comb begin
    win_idx = '0;
    for (int k = NFLT - 1; k >= 0; k--)
      if (hit_vec[k]) win_idx = IW'(k);
  end

  assign found = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld <= 1'b0;
      acc_ok  <= 1'b0;
      acc_hit <= 1'b0;
      acc_idx <= '0;
    end else begin
      acc_vld <= frm_vld;
      acc_ok  <= frm_vld && (found || (en_q == '0));
      acc_hit <= frm_vld && found;
      acc_idx <= frm_vld ? win_idx : '0;
    end
  end
endmodule

// File: rtl/rxflt_bank.sv
module rxflt_bank
  import rxflt_pkg::*;
#(
  parameter int NFLT = 4,
  parameter int AW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [AW-1:0]           bus_addr,
  input  logic [ID_W-1:0]         bus_wdata,
  output logic [ID_W-1:0]         bus_rdata,
  input  logic                    frm_vld,
  input  logic [ID_W-1:0]         frm_id,
  output logic                    acc_vld,
  output logic                    acc_ok,
  output logic                    acc_hit,
  output logic [$clog2(NFLT)-1:0] acc_idx
);
  localparam int IW = $clog2(NFLT);

  logic [NFLT-1:0]           en_q;
  logic [NFLT-1:0][ID_W-1:0] mask_q, ref_q;
  logic [NFLT-1:0]           hit_vec;
  logic                      wr_block;
  logic [2*NFLT*ID_W-1:0]    cfg_flat;

  assign cfg_flat = {mask_q, ref_q};

  rxflt_regs #(.NFLT(NFLT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .en_q(en_q), .mask_q(mask_q), .ref_q(ref_q), .wr_block(wr_block)
  );

  for (genvar k = 0; k < NFLT; k++) begin : g_cmp
    rxflt_cmp u_cmp (
      .on(en_q[k]), .fid(frm_id), .msk(mask_q[k]),
      .ref_id(ref_q[k]), .hit(hit_vec[k])
    );
  end

  rxflt_pick #(.NFLT(NFLT), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .hit_vec(hit_vec),
    .en_q(en_q), .acc_vld(acc_vld), .acc_ok(acc_ok),
    .acc_hit(acc_hit), .acc_idx(acc_idx)
  );
endmodule

// File: rtl/rxflt_chk.sv
module rxflt_chk #(
  parameter int NFLT = 4,
  parameter int CW   = 256
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frm_vld,
  input logic                    acc_vld,
  input logic                    acc_ok,
  input logic                    acc_hit,
  input logic [$clog2(NFLT)-1:0] acc_idx,
  input logic [NFLT-1:0]         en_q,
  input logic [NFLT-1:0]         hit_vec,
  input logic                    wr_block,
  input logic [CW-1:0]           cfg_flat
);
  logic [NFLT-1:0] prev_hit;
  logic [NFLT-1:0] below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_hit <= '0;
    else        prev_hit <= hit_vec;
  end

  assign below = (NFLT'(1) << acc_idx) - NFLT'(1);

  a_r8_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> acc_vld);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> !acc_vld);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> (!acc_ok && !acc_hit && acc_idx == '0));
  a_r4_hit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_ok);
  a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && hit_vec == '0 && en_q != '0) |=> !acc_ok);
  a_r5_open: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && en_q == '0) |=> (acc_ok && !acc_hit));
  a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (prev_hit[acc_idx] && (prev_hit & below) == '0));
  a_r6_protect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> $stable(cfg_flat));
endmodule

bind rxflt_bank rxflt_chk #(.NFLT(NFLT), .CW(2 * NFLT * rxflt_pkg::ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .acc_vld(acc_vld),
  .acc_ok(acc_ok), .acc_hit(acc_hit), .acc_idx(acc_idx), .en_q(en_q),
  .hit_vec(hit_vec), .wr_block(wr_block), .cfg_flat(cfg_flat)
);

// File: tb/sim_rxflt_bank.sv
module sim_rxflt_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, frm_vld = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, frm_id = '0;
  logic [31:0] bus_rdata;
  logic        acc_vld, acc_ok, acc_hit;
  logic [1:0]  acc_idx;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  rxflt_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frm_vld(frm_vld), .frm_id(frm_id), .acc_vld(acc_vld),
    .acc_ok(acc_ok), .acc_hit(acc_hit), .acc_idx(acc_idx)
  );

  // ---------------- behavioural reference ----------------
  int unsigned m_mask[4], m_ref[4];
  int unsigned m_en;
  bit          e_vld, e_ok, e_hit;
  int          e_idx;
  int unsigned e_rdata;

  function automatic int unsigned m_read(int unsigned a);
    int unsigned rel;
    if (a == 'h60) return m_en;
    if (a < 'h64 || a > 'h83) return 0;
    rel = a - 'h64;
    if (rel % 4 != 0) return 0;
    return ((rel / 4) % 2 == 0) ? m_mask[rel / 8] : m_ref[rel / 8];
  endfunction

  task automatic m_write(int unsigned a, int unsigned d);
    int unsigned rel, f;
    if (a == 'h60) begin
      m_en = d & 'hF;
      return;
    end
    if (a < 'h64 || a > 'h83) return;
    rel = a - 'h64;
    if (rel % 4 != 0) return;
    f = rel / 8;
    if (m_en[f]) return;
    if ((rel / 4) % 2 == 0) m_mask[f] = d;
    else                    m_ref[f]  = d;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_mask[k] = 0;
        m_ref[k]  = 0;
      end
      m_en = 0; e_vld = 0; e_ok = 0; e_hit = 0; e_idx = 0; e_rdata = 0;
    end else begin
      int first;
      first = -1;
      e_vld = frm_vld; e_ok = 0; e_hit = 0; e_idx = 0;
      if (frm_vld) begin
        for (int k = 0; k < 4; k++)
          if (first < 0 && m_en[k] && ((frm_id & m_mask[k]) == (m_ref[k] & m_mask[k])))
            first = k;
        e_hit = (first >= 0);
        e_ok  = e_hit || (m_en == 0);
        e_idx = e_hit ? first : 0;
      end
      if (bus_rd) e_rdata = m_read(bus_addr);
      if (bus_wr) m_write(bus_addr, bus_wdata);
    end
  end

  task automatic chk(bit ok, string req, int unsigned act, int unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(acc_vld == e_vld, "R8 valid", acc_vld, e_vld);
      chk(acc_ok == e_ok, "R4 keep", acc_ok, e_ok);
      chk(acc_hit == e_hit, "R4 hit", acc_hit, e_hit);
      chk(acc_idx == e_idx[1:0], "R7 index", acc_idx, e_idx);
      chk(bus_rdata == e_rdata, "R2 R10 readback", bus_rdata, e_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int unsigned a, int unsigned d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int unsigned a, output int unsigned v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a[7:0];
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic frame(int unsigned id);
    @(negedge clk);
    frm_vld = 1; frm_id = id;
    @(negedge clk);
    frm_vld = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(!acc_vld && !acc_ok && !acc_hit && acc_idx == 0, "R1 outputs", acc_ok, 0);
    rd('h60, v); chk(v == 0, "R1 enable", v, 0);
    rd('h7C, v); chk(v == 0, "R1 mask3", v, 0);

    // program bank with enables cleared
    wr('h60, 0);
    wr('h64, 'hF7);   wr('h68, 'h121F);
    wr('h6C, 'h5431); wr('h70, 'h14);
    wr('h74, 'h1234); wr('h78, 'h5431);
    wr('h7C, 'hFFF);  wr('h80, 'h1234);
    rd('h70, v); chk(v == 'h14, "R2 ref1 readback", v, 'h14);
    wr('h60, 'hFFFF_FFFF);
    rd('h60, v); chk(v == 'hF, "R2 enable upper bits", v, 'hF);

    // R4: identifier 0x14 passes through filter 1 only
    frame('h14);
    chk(acc_ok && acc_hit, "R4 accepted", acc_ok, 1);
    chk(acc_idx == 1, "R4 index", acc_idx, 1);
    frame('h9999);
    chk(!acc_ok, "R4 rejected", acc_ok, 0);

    // R6: write to an enabled filter is dropped
    wr('h64, 'h0); wr('h68, 'hABCD);
    rd('h64, v); chk(v == 'hF7, "R6 mask0 kept", v, 'hF7);
    rd('h68, v); chk(v == 'h121F, "R6 ref0 kept", v, 'h121F);

    // R7: open filter 0 so both 0 and 1 match
    wr('h60, 'hE);
    wr('h64, 'h0);
    wr('h60, 'hF);
    frame('h14);
    chk(acc_hit && acc_idx == 0, "R7 lowest wins", acc_idx, 0);

    // R3: masked-out bits are ignored (filter 3 only)
    wr('h60, 'h8);
    frame('hABC234);
    chk(acc_ok && acc_idx == 3, "R3 masked compare", acc_idx, 3);
    frame('hABC235);
    chk(!acc_ok, "R3 care bit differs", acc_ok, 0);

    // R5: nothing enabled keeps everything
    wr('h60, 0);
    frame('hDEAD_BEEF);
    chk(acc_ok && !acc_hit, "R5 open bank", acc_ok, 1);

    // R9: unmapped addresses
    wr('h84, 'h5555); wr('h66, 'h7777);
    rd('h84, v); chk(v == 0, "R9 unmapped read", v, 0);
    rd('h64, v); chk(v == 0, "R9 mask0 untouched", v, 0);

    // R8: back-to-back frames
    @(negedge clk); frm_vld = 1; frm_id = 1;
    @(negedge clk); frm_id = 2;
    @(negedge clk); frm_vld = 0;
    chk(acc_vld, "R8 second verdict", acc_vld, 1);
    @(negedge clk);
    chk(!acc_vld, "R8 verdict ends", acc_vld, 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      @(negedge clk);
      sel = $urandom % 11;
      bus_wr    = ($urandom % 4) == 0;
      bus_rd    = ($urandom % 3) == 0;
      bus_addr  = (sel == 10) ? 8'h84 : 8'h60 + 8'(sel * 4);
      bus_wdata = (sel == 0) ? ($urandom % 16) : ($urandom & 'h1F);
      frm_vld   = ($urandom % 2) == 0;
      frm_id    = $urandom & 'h1F;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; frm_vld = 0;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule